// File: doc/BRIEF.md
# Event-Driven Output Matrix

This block sits next to a free-running or externally controlled counter and turns counter values and pin levels into output waveforms. It holds a set of events, each of which watches one match value, one input or output signal, or both, and fires on the counter step in which its condition holds. Every event is gated by a 5-bit state variable: an event is live only in the states its 32-bit enable mask lists, and an event that fires can either load a new state or add a value to the current one. Sequences of behaviour (for example a PWM phase followed by a dead period) are built this way without any processor help.

Each output has a set mask and a clear mask over the events, so any event can drive any output high or low. When the same step both sets and clears an output, a 2-bit rule per output picks the result: hold, set, clear or toggle. Fired events leave sticky flags, cleared by writing ones, which feed an interrupt line through an enable mask; outputs that saw a set/clear collision leave a second set of sticky flags. While the counter is halted, all outputs can be written at once to place their starting levels.

All configuration arrives on flat parallel ports from a register block outside this module. The reset input is asynchronous, active low, and is expected to be released synchronously to the clock.

Top module: `eom_matrix`

## Requirements
- R1: After reset, outputs, state variable, event flags, conflict flags and interrupt line are all zero.
- R2: An event fires only in a clock cycle with `step_i` high and only when bit number `state_o` of its 32-bit enable mask is 1.
- R3: Control bits 13:12 pick the firing rule: 0 match or condition, 1 match only, 2 condition only, 3 match and condition.
- R4: Control bits 3:0 select the match register (a value of N_MATCH or above never matches); bit 20 = 0 matches on equality, bit 20 = 1 matches when the counter is at or above the value while counting up, at or below it while counting down.
- R5: Control bits 22:21 restrict the event to any direction (0), counting up only (1), counting down only (2), or never (3); `cnt_down_i` high means counting down.
- R6: Bit 5 chooses the watched signal from the outputs (1) or the inputs (0), bits 9:6 give its index, and bits 11:10 give the condition: 0 low, 1 rising, 2 falling, 3 high, where edges compare the present level with the level one clock earlier.
- R7: An output goes high on the clock edge of a step in which an event of its set mask fires, low when an event of its clear mask fires, and otherwise holds.
- R8: When set and clear hit one output in the same step, its 2-bit rule applies: 0 hold, 1 high, 2 low, 3 invert.
- R9: A firing event with bit 14 = 1 loads bits 19:15 into the state; with bit 14 = 0 it adds them (modulo 32). Among loads the highest-numbered event wins and loads override all adds; otherwise the adds of all firing events are summed. A direct state write overrides events.
- R10: A direct output write sets all outputs to `out_wr_data_i` only while `halted_i` is high; with `halted_i` low it has no effect.
- R11: Each event flag is set when its event fires and stays set until a 1 is written to that bit of `flag_clr_i`; a fire in the same cycle as the clear keeps the flag set.
- R12: `irq_o` is high exactly when some event flag is set whose bit in `int_en_i` is 1.
- R13: An output's conflict flag is set when set and clear hit it in the same step, and is cleared by a 1 in `cflag_clr_i`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| step_i | input | 1 | Counter advances this cycle; events are evaluated |
| cnt_i | input | CW | Present counter value |
| cnt_down_i | input | 1 | Counter is counting down |
| halted_i | input | 1 | Counter is halted; direct output writes accepted |
| in_i | input | N_IN | Input signals for event conditions |
| match_val_i | input | N_MATCH*CW | Match values, register m in bits m*CW upward |
| evt_mask_i | input | N_EVT*32 | State enable mask per event |
| evt_ctrl_i | input | N_EVT*23 | Control word per event |
| set_mask_i | input | N_OUT*N_EVT | Events that set each output |
| clr_mask_i | input | N_OUT*N_EVT | Events that clear each output |
| policy_i | input | N_OUT*2 | Collision rule per output |
| out_wr_i | input | 1 | Direct output write strobe |
| out_wr_data_i | input | N_OUT | Direct output write value |
| state_wr_i | input | 1 | Direct state write strobe |
| state_wr_data_i | input | 5 | Direct state write value |
| int_en_i | input | N_EVT | Interrupt enable per event flag |
| flag_clr_i | input | N_EVT | Write-one-to-clear for event flags |
| cflag_clr_i | input | N_OUT | Write-one-to-clear for conflict flags |
| out_o | output | N_OUT | Output levels |
| state_o | output | 5 | State variable |
| evt_flag_o | output | N_EVT | Sticky event flags |
| cflag_o | output | N_OUT | Sticky conflict flags |
| irq_o | output | 1 | Interrupt request |

## Verification
A wrong state variable shows up one step later as events firing or staying silent against their masks, so every state value is walked and read back through a single gated event's flag on the very next edge. A wrong output register or collision rule is visible on `out_o` one clock after the step, and each combination of prior level, set, clear and rule is driven on every output. A stale previous-level register would make edge conditions misfire on the first step after an input change, which the edge sweep exposes in the same cycle.

// File: rtl/eom_pkg.sv
package eom_pkg;

  localparam int STW    = 5;
  localparam int N_ST   = 1 << STW;
  localparam int EVT_CW = 23;

  typedef enum logic [1:0] {
    CMB_EITHER = 2'd0,
    CMB_MATCH  = 2'd1,
    CMB_SIG    = 2'd2,
    CMB_BOTH   = 2'd3
  } combine_e;

  typedef enum logic [1:0] {
    LVL_LOW  = 2'd0,
    LVL_RISE = 2'd1,
    LVL_FALL = 2'd2,
    LVL_HIGH = 2'd3
  } level_e;

  typedef enum logic [1:0] {
    DIR_ANY  = 2'd0,
    DIR_UP   = 2'd1,
    DIR_DOWN = 2'd2,
    DIR_NONE = 2'd3
  } dir_e;

  typedef enum logic [1:0] {
    POL_HOLD = 2'd0,
    POL_SET  = 2'd1,
    POL_CLR  = 2'd2,
    POL_FLIP = 2'd3
  } policy_e;

  typedef struct packed {
    dir_e        dir;
    logic        relcmp;
    logic [STW-1:0] st_val;
    logic        st_load;
    combine_e    combine;
    level_e      level;
    logic [3:0]  sig_idx;
    logic        use_out;
    logic        rsv;
    logic [3:0]  match_sel;
  } evt_ctrl_t;

endpackage

// File: rtl/eom_event.sv
module eom_event
  import eom_pkg::*;
#(
  parameter int CW      = 16,
  parameter int N_MATCH = 8,
  parameter int N_IN    = 4,
  parameter int N_OUT   = 6
) (
  input  logic                  step_i,
  input  evt_ctrl_t             ctrl_i,
  input  logic [N_ST-1:0]       mask_i,
  input  logic [STW-1:0]        state_i,
  input  logic [CW-1:0]         cnt_i,
  input  logic                  cnt_down_i,
  input  logic [N_MATCH*CW-1:0] match_val_i,
  input  logic [N_IN-1:0]       in_now_i,
  input  logic [N_IN-1:0]       in_prev_i,
  input  logic [N_OUT-1:0]      out_now_i,
  input  logic [N_OUT-1:0]      out_prev_i,
  output logic                  fire_o
);

  logic [CW-1:0] mval;
  logic          msel_ok;
  logic          match_hit;
  logic          dir_ok;
  logic          sig_now;
  logic          sig_prev;
  logic          level_hit;
  logic          rule_hit;
  logic [15:0]   in_now_x, in_prev_x, out_now_x, out_prev_x;
  logic          unused_rsv;

  assign unused_rsv = ctrl_i.rsv;

  // match register selection
  always_comb begin
    mval    = '0;
    msel_ok = 1'b0;
    for (int m = 0; m < N_MATCH; m++) begin
      if (ctrl_i.match_sel == 4'(m)) begin
        mval    = match_val_i[m*CW +: CW];
        msel_ok = 1'b1;
      end
    end
  end

  always_comb begin
    if (!ctrl_i.relcmp)  match_hit = msel_ok && (cnt_i == mval);
    else if (cnt_down_i) match_hit = msel_ok && (cnt_i <= mval);
    else                 match_hit = msel_ok && (cnt_i >= mval);
  end

  always_comb begin
    unique case (ctrl_i.dir)
      DIR_ANY:  dir_ok = 1'b1;
      DIR_UP:   dir_ok = !cnt_down_i;
      DIR_DOWN: dir_ok = cnt_down_i;
      default:  dir_ok = 1'b0;
    endcase
  end

  // signal selection and level condition
  assign in_now_x   = 16'(in_now_i);
  assign in_prev_x  = 16'(in_prev_i);
  assign out_now_x  = 16'(out_now_i);
  assign out_prev_x = 16'(out_prev_i);
  assign sig_now    = ctrl_i.use_out ? out_now_x[ctrl_i.sig_idx]  : in_now_x[ctrl_i.sig_idx];
  assign sig_prev   = ctrl_i.use_out ? out_prev_x[ctrl_i.sig_idx] : in_prev_x[ctrl_i.sig_idx];

  always_comb begin
    unique case (ctrl_i.level)
      LVL_LOW:  level_hit = !sig_now;
      LVL_RISE: level_hit = sig_now && !sig_prev;
      LVL_FALL: level_hit = !sig_now && sig_prev;
      default:  level_hit = sig_now;
    endcase
  end

  always_comb begin
    unique case (ctrl_i.combine)
      CMB_EITHER: rule_hit = match_hit || level_hit;
      CMB_MATCH:  rule_hit = match_hit;
      CMB_SIG:    rule_hit = level_hit;
      default:    rule_hit = match_hit && level_hit;
    endcase
  end

  assign fire_o = step_i && mask_i[state_i] && dir_ok && rule_hit;

endmodule

// File: rtl/eom_outcell.sv
module eom_outcell
  import eom_pkg::*;
#(
  parameter int N_EVT = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_EVT-1:0] fire_i,
  input  logic [N_EVT-1:0] set_mask_i,
  input  logic [N_EVT-1:0] clr_mask_i,
  input  policy_e          policy_i,
  input  logic             wr_en_i,
  input  logic             wr_val_i,
  output logic             out_o,
  output logic             conflict_o
);

  logic set_hit, clr_hit, upd_en;
  logic out_q, out_d;

  assign set_hit    = |(fire_i & set_mask_i);
  assign clr_hit    = |(fire_i & clr_mask_i);
  assign conflict_o = set_hit && clr_hit;
  assign upd_en     = wr_en_i || set_hit || clr_hit;

  always_comb begin
    out_d = out_q;
    if (wr_en_i) begin
      out_d = wr_val_i;
    end else if (set_hit && clr_hit) begin
      unique case (policy_i)
        POL_HOLD: out_d = out_q;
        POL_SET:  out_d = 1'b1;
        POL_CLR:  out_d = 1'b0;
        default:  out_d = !out_q;
      endcase
    end else if (set_hit) begin
      out_d = 1'b1;
    end else if (clr_hit) begin
      out_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      out_q <= 1'b0;
    else if (upd_en) out_q <= out_d;
  end

  assign out_o = out_q;

endmodule

// File: rtl/eom_matrix.sv
module eom_matrix
  import eom_pkg::*;
#(
  parameter int CW      = 16,
  parameter int N_EVT   = 8,
  parameter int N_OUT   = 6,
  parameter int N_IN    = 4,
  parameter int N_MATCH = 8
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    step_i,
  input  logic [CW-1:0]           cnt_i,
  input  logic                    cnt_down_i,
  input  logic                    halted_i,
  input  logic [N_IN-1:0]         in_i,
  input  logic [N_MATCH*CW-1:0]   match_val_i,
  input  logic [N_EVT*N_ST-1:0]   evt_mask_i,
  input  logic [N_EVT*EVT_CW-1:0] evt_ctrl_i,
  input  logic [N_OUT*N_EVT-1:0]  set_mask_i,
  input  logic [N_OUT*N_EVT-1:0]  clr_mask_i,
  input  logic [N_OUT*2-1:0]      policy_i,
  input  logic                    out_wr_i,
  input  logic [N_OUT-1:0]        out_wr_data_i,
  input  logic                    state_wr_i,
  input  logic [STW-1:0]          state_wr_data_i,
  input  logic [N_EVT-1:0]        int_en_i,
  input  logic [N_EVT-1:0]        flag_clr_i,
  input  logic [N_OUT-1:0]        cflag_clr_i,
  output logic [N_OUT-1:0]        out_o,
  output logic [STW-1:0]          state_o,
  output logic [N_EVT-1:0]        evt_flag_o,
  output logic [N_OUT-1:0]        cflag_o,
  output logic                    irq_o
);

  logic [N_EVT-1:0] fire;
  logic [N_OUT-1:0] conflict;
  logic [N_OUT-1:0] out_now, out_prev_q;
  logic [N_IN-1:0]  in_prev_q;
  logic [STW-1:0]   state_q, state_d;
  logic [N_EVT-1:0] flag_q, flag_d;
  logic [N_OUT-1:0] cflag_q, cflag_d;
  logic             out_wr_en;
  evt_ctrl_t        ctrl [N_EVT];

  assign out_wr_en = halted_i && out_wr_i;

  // event evaluators
  for (genvar e = 0; e < N_EVT; e++) begin : g_evt
    assign ctrl[e] = evt_ctrl_t'(evt_ctrl_i[e*EVT_CW +: EVT_CW]);
    eom_event #(
      .CW(CW), .N_MATCH(N_MATCH), .N_IN(N_IN), .N_OUT(N_OUT)
    ) u_evt (
      .step_i     (step_i),
      .ctrl_i     (ctrl[e]),
      .mask_i     (evt_mask_i[e*N_ST +: N_ST]),
      .state_i    (state_q),
      .cnt_i      (cnt_i),
      .cnt_down_i (cnt_down_i),
      .match_val_i(match_val_i),
      .in_now_i   (in_i),
      .in_prev_i  (in_prev_q),
      .out_now_i  (out_now),
      .out_prev_i (out_prev_q),
      .fire_o     (fire[e])
    );
  end

  // output cells
  for (genvar o = 0; o < N_OUT; o++) begin : g_out
    eom_outcell #(.N_EVT(N_EVT)) u_cell (
      .clk       (clk),
      .rst_n     (rst_n),
      .fire_i    (fire),
      .set_mask_i(set_mask_i[o*N_EVT +: N_EVT]),
      .clr_mask_i(clr_mask_i[o*N_EVT +: N_EVT]),
      .policy_i  (policy_e'(policy_i[o*2 +: 2])),
      .wr_en_i   (out_wr_en),
      .wr_val_i  (out_wr_data_i[o]),
      .out_o     (out_now[o]),
      .conflict_o(conflict[o])
    );
  end

  // state update: loads beat adds, highest load index wins
  always_comb begin
    logic            ld_any;
    logic [STW-1:0]  ld_val;
    logic [STW-1:0]  add_sum;
    ld_any  = 1'b0;
    ld_val  = '0;
    add_sum = '0;
    for (int e = 0; e < N_EVT; e++) begin
      if (fire[e]) begin
        if (ctrl[e].st_load) begin
          ld_any = 1'b1;
          ld_val = ctrl[e].st_val;
        end else begin
          add_sum = add_sum + ctrl[e].st_val;
        end
      end
    end
    if (state_wr_i)  state_d = state_wr_data_i;
    else if (ld_any) state_d = ld_val;
    else             state_d = state_q + add_sum;
  end

  assign flag_d  = (flag_q & ~flag_clr_i) | fire;
  assign cflag_d = (cflag_q & ~cflag_clr_i) | conflict;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q    <= '0;
      flag_q     <= '0;
      cflag_q    <= '0;
      in_prev_q  <= '0;
      out_prev_q <= '0;
    end else begin
      state_q    <= state_d;
      flag_q     <= flag_d;
      cflag_q    <= cflag_d;
      in_prev_q  <= in_i;
      out_prev_q <= out_now;
    end
  end

  assign out_o      = out_now;
  assign state_o    = state_q;
  assign evt_flag_o = flag_q;
  assign cflag_o    = cflag_q;
  assign irq_o      = |(flag_q & int_en_i);

endmodule

// File: rtl/eom_chk.sv
module eom_chk
  import eom_pkg::*;
#(
  parameter int N_EVT = 8,
  parameter int N_OUT = 6
) (
  input logic             clk,
  input logic             rst_n,
  input logic             step_i,
  input logic             halted_i,
  input logic             out_wr_i,
  input logic [N_OUT-1:0] out_wr_data_i,
  input logic             state_wr_i,
  input logic [STW-1:0]   state_wr_data_i,
  input logic [N_EVT-1:0] flag_clr_i,
  input logic [N_OUT-1:0] cflag_clr_i,
  input logic [N_EVT-1:0] int_en_i,
  input logic [N_EVT-1:0] fire,
  input logic [N_OUT-1:0] out_o,
  input logic [STW-1:0]   state_o,
  input logic [N_EVT-1:0] evt_flag_o,
  input logic [N_OUT-1:0] cflag_o,
  input logic             irq_o
);

  AST_RESET_QUIET: assert property (@(posedge clk) !rst_n |-> (out_o == '0 && evt_flag_o == '0 && !irq_o)); // R1

  AST_NO_STEP_NO_FIRE: assert property (@(posedge clk) disable iff (!rst_n) !step_i |-> fire == '0); // R2

  AST_OUT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !(halted_i && out_wr_i)) |=> $stable(out_o)); // R7

  AST_STATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && !state_wr_i) |=> $stable(state_o)); // R9

  AST_STATE_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    state_wr_i |=> state_o == $past(state_wr_data_i)); // R9

  AST_HALT_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (halted_i && out_wr_i) |=> out_o == $past(out_wr_data_i)); // R10

  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && flag_clr_i == '0) |=> $stable(evt_flag_o)); // R11

  AST_FLAG_SET: assert property (@(posedge clk) disable iff (!rst_n)
    fire != '0 |=> (evt_flag_o & $past(fire)) == $past(fire)); // R11

  AST_IRQ_MASKED: assert property (@(posedge clk) disable iff (!rst_n)
    int_en_i == '0 |-> !irq_o); // R12

  AST_CFLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!step_i && cflag_clr_i == '0) |=> $stable(cflag_o)); // R13

endmodule

bind eom_matrix eom_chk #(.N_EVT(N_EVT), .N_OUT(N_OUT)) u_chk (
  .clk(clk), .rst_n(rst_n), .step_i(step_i), .halted_i(halted_i),
  .out_wr_i(out_wr_i), .out_wr_data_i(out_wr_data_i),
  .state_wr_i(state_wr_i), .state_wr_data_i(state_wr_data_i),
  .flag_clr_i(flag_clr_i), .cflag_clr_i(cflag_clr_i), .int_en_i(int_en_i),
  .fire(fire), .out_o(out_o), .state_o(state_o), .evt_flag_o(evt_flag_o),
  .cflag_o(cflag_o), .irq_o(irq_o)
);

// File: tb/tb_eom_matrix.sv
`timescale 1ns/1ps
module tb_eom_matrix;
  localparam int CW = 16, NE = 8, NO = 6, NI = 4, NM = 8;

  logic clk, rst_n, step_i, cnt_down_i, halted_i, out_wr_i, state_wr_i;
  logic [CW-1:0]    cnt_i;
  logic [NI-1:0]    in_i;
  logic [NM*CW-1:0] match_val_i;
  logic [NE*32-1:0] evt_mask_i;
  logic [NE*23-1:0] evt_ctrl_i;
  logic [NO*NE-1:0] set_mask_i, clr_mask_i;
  logic [NO*2-1:0]  policy_i;
  logic [NO-1:0]    out_wr_data_i, cflag_clr_i, out_o, cflag_o;
  logic [4:0]       state_wr_data_i, state_o;
  logic [NE-1:0]    int_en_i, flag_clr_i, evt_flag_o;
  logic             irq_o;

  int n_chk = 0, n_err = 0;
  bit done = 0;

  eom_matrix #(.CW(CW), .N_EVT(NE), .N_OUT(NO), .N_IN(NI), .N_MATCH(NM)) dut (.*);

  initial clk = 1'b0;
  always #2.5 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  function automatic logic [22:0] mk(input int msel, input bit uo, input int idx, input int lvl,
                                     input int cmb, input bit ld, input int val, input bit rel, input int dir);
    return {2'(dir), rel, 5'(val), ld, 2'(cmb), 2'(lvl), 4'(idx), uo, 1'b0, 4'(msel)};
  endfunction

  task automatic cfg_clear();
    evt_ctrl_i = '0; evt_mask_i = '0; set_mask_i = '0; clr_mask_i = '0;
    policy_i = '0; match_val_i = '0;
  endtask

  task automatic set_evt(input int e, input logic [22:0] c, input logic [31:0] m);
    evt_ctrl_i[e*23 +: 23] = c;
    evt_mask_i[e*32 +: 32] = m;
  endtask

  task automatic do_step(input logic [CW-1:0] c, input bit dn);
    cnt_i = c; cnt_down_i = dn; step_i = 1'b1;
    tick();
    step_i = 1'b0;
  endtask

  task automatic wr_out(input logic [NO-1:0] v);
    halted_i = 1'b1; out_wr_i = 1'b1; out_wr_data_i = v;
    tick();
    halted_i = 1'b0; out_wr_i = 1'b0;
  endtask

  task automatic wr_state(input int s);
    state_wr_i = 1'b1; state_wr_data_i = 5'(s);
    tick();
    state_wr_i = 1'b0;
  endtask

  task automatic clr_flags();
    flag_clr_i = '1; cflag_clr_i = '1;
    tick();
    flag_clr_i = '0; cflag_clr_i = '0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_chk++; n_err++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; step_i = 0; cnt_i = '0; cnt_down_i = 0; halted_i = 0; in_i = '0;
    out_wr_i = 0; out_wr_data_i = '0; state_wr_i = 0; state_wr_data_i = '0;
    int_en_i = '0; flag_clr_i = '0; cflag_clr_i = '0;
    cfg_clear();
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk("R1 reset out", 32'(out_o), 0);
    chk("R1 reset state", 32'(state_o), 0);
    chk("R1 reset flags", 32'(evt_flag_o), 0);
    chk("R1 reset cflags", 32'(cflag_o), 0);
    chk("R1 reset irq", 32'(irq_o), 0);

    // R7 R8 R13: every output, rule, prior level, set/clear combination
    in_i = 4'b0001;
    for (int o = 0; o < NO; o++)
      for (int pol = 0; pol < 4; pol++)
        for (int init = 0; init < 2; init++)
          for (int sc = 0; sc < 4; sc++) begin
            logic expv;
            cfg_clear();
            set_evt(0, mk(0, 0, 0, 3, 2, 0, 0, 0, 0), 32'h1);
            set_mask_i[o*NE] = sc[1];
            clr_mask_i[o*NE] = sc[0];
            policy_i[o*2 +: 2] = 2'(pol);
            wr_out(6'(init) << o);
            clr_flags();
            do_step(16'd5, 0);
            if (sc == 3) expv = (pol == 0) ? init[0] : (pol == 1) ? 1'b1 : (pol == 2) ? 1'b0 : !init[0];
            else if (sc == 2) expv = 1'b1;
            else if (sc == 1) expv = 1'b0;
            else expv = init[0];
            chk($sformatf("R8 R7 out o=%0d pol=%0d init=%0d sc=%0d", o, pol, init, sc),
                32'(out_o), 32'(6'(expv) << o));
            chk($sformatf("R13 cflag o=%0d sc=%0d", o, sc), 32'(cflag_o), (sc == 3) ? 32'(6'(1) << o) : 0);
          end
    // R13 write-one clear
    clr_flags();
    chk("R13 cflag cleared", 32'(cflag_o), 0);

    // R3: combine rules over match and condition truth
    for (int c = 0; c < 4; c++)
      for (int mh = 0; mh < 2; mh++)
        for (int ch = 0; ch < 2; ch++) begin
          bit ex;
          cfg_clear();
          match_val_i[0 +: CW] = 16'd100;
          set_evt(1, mk(0, 0, 1, 3, c, 0, 0, 0, 0), 32'h1);
          in_i = 4'(ch << 1);
          clr_flags();
          do_step(mh ? 16'd100 : 16'd50, 0);
          ex = (c == 0) ? (mh | ch) : (c == 1) ? mh[0] : (c == 2) ? ch[0] : (mh & ch);
          chk($sformatf("R3 comb=%0d m=%0d c=%0d", c, mh, ch), 32'(evt_flag_o), 32'(ex) << 1);
        end

    // R6: level conditions with previous and present levels of an input
    for (int lv = 0; lv < 4; lv++)
      for (int p = 0; p < 2; p++)
        for (int n = 0; n < 2; n++) begin
          bit ex;
          cfg_clear();
          set_evt(2, mk(0, 0, 2, lv, 2, 0, 0, 0, 0), 32'h1);
          in_i = 4'(p << 2);
          clr_flags();
          in_i = 4'(n << 2);
          do_step(16'd0, 0);
          ex = (lv == 0) ? !n[0] : (lv == 1) ? (n[0] & !p[0]) : (lv == 2) ? (!n[0] & p[0]) : n[0];
          chk($sformatf("R6 lvl=%0d prev=%0d now=%0d", lv, p, n), 32'(evt_flag_o), 32'(ex) << 2);
        end
    // R6: condition taken from an output
    for (int v = 0; v < 2; v++) begin
      cfg_clear();
      set_evt(2, mk(0, 1, 3, 3, 2, 0, 0, 0, 0), 32'h1);
      wr_out(6'(v << 3));
      clr_flags();
      do_step(16'd0, 0);
      chk($sformatf("R6 output source v=%0d", v), 32'(evt_flag_o), 32'(v) << 2);
    end

    // R4 R5: compare mode, direction filter, counter direction
    for (int rel = 0; rel < 2; rel++)
      for (int dir = 0; dir < 4; dir++)
        for (int dn = 0; dn < 2; dn++)
          for (int k = 0; k < 3; k++) begin
            int cv; bit mh, dok;
            cv = 999 + k;
            cfg_clear();
            match_val_i[2*CW +: CW] = 16'd1000;
            set_evt(3, mk(2, 0, 0, 0, 1, 0, 0, rel[0], dir), 32'h1);
            clr_flags();
            do_step(16'(cv), dn[0]);
            mh  = (rel == 0) ? (cv == 1000) : (dn ? (cv <= 1000) : (cv >= 1000));
            dok = (dir == 0) || (dir == 1 && dn == 0) || (dir == 2 && dn == 1);
            chk($sformatf("R4 R5 rel=%0d dir=%0d dn=%0d cnt=%0d", rel, dir, dn, cv),
                32'(evt_flag_o), 32'(mh & dok) << 3);
          end
    // R4: out-of-range match select never matches
    cfg_clear();
    set_evt(3, mk(9, 0, 0, 0, 1, 0, 0, 0, 0), 32'h1);
    clr_flags();
    do_step(16'd0, 0);
    chk("R4 match select beyond registers", 32'(evt_flag_o), 0);

    // R2: state gating over every state value, and no fire without a step
    in_i = 4'b0001;
    for (int s = 0; s < 32; s++) begin
      logic [31:0] m;
      m = 32'hA5C3_0F69;
      cfg_clear();
      set_evt(2, mk(0, 0, 0, 3, 2, 0, 0, 0, 0), m);
      wr_state(s);
      clr_flags();
      do_step(16'd0, 0);
      chk($sformatf("R2 state=%0d", s), 32'(evt_flag_o), 32'(m[s]) << 2);
    end
    cfg_clear();
    set_evt(0, mk(0, 0, 0, 3, 2, 0, 0, 0, 0), 32'hFFFF_FFFF);
    clr_flags();
    tick();
    chk("R2 no step no fire", 32'(evt_flag_o), 0);

    // R9: adds summed, wrap, load precedence, highest load wins
    cfg_clear();
    set_evt(4, mk(0, 0, 0, 3, 2, 0, 3, 0, 0), 32'hFFFF_FFFF);
    set_evt(5, mk(0, 0, 0, 3, 2, 0, 7, 0, 0), 32'hFFFF_FFFF);
    wr_state(0);
    chk("R9 direct state write", 32'(state_o), 0);
    do_step(16'd0, 0);
    chk("R9 adds summed", 32'(state_o), 10);
    wr_state(30);
    do_step(16'd0, 0);
    chk("R9 add wraps", 32'(state_o), (30 + 10) % 32);
    set_evt(6, mk(0, 0, 0, 3, 2, 1, 20, 0, 0), 32'hFFFF_FFFF);
    do_step(16'd0, 0);
    chk("R9 load beats adds", 32'(state_o), 20);
    set_evt(7, mk(0, 0, 0, 3, 2, 1, 9, 0, 0), 32'hFFFF_FFFF);
    do_step(16'd0, 0);
    chk("R9 highest load wins", 32'(state_o), 9);
    state_wr_i = 1'b1; state_wr_data_i = 5'd17; step_i = 1'b1;
    tick();
    state_wr_i = 1'b0; step_i = 1'b0;
    chk("R9 write beats events", 32'(state_o), 17);

    // R11 R12: sticky flags, write-one clear, set wins, interrupt mask
    cfg_clear();
    wr_state(0);
    set_evt(0, mk(0, 0, 0, 3, 2, 0, 0, 0, 0), 32'h1);
    clr_flags();
    int_en_i = 8'h00;
    do_step(16'd0, 0);
    tick();
    chk("R11 flag sticky", 32'(evt_flag_o), 1);
    chk("R12 irq masked", 32'(irq_o), 0);
    int_en_i = 8'h02;
    tick();
    chk("R12 irq other enable", 32'(irq_o), 0);
    int_en_i = 8'h01;
    tick();
    chk("R12 irq enabled", 32'(irq_o), 1);
    flag_clr_i = 8'hFE;
    tick();
    flag_clr_i = '0;
    chk("R11 clear other bits", 32'(evt_flag_o), 1);
    flag_clr_i = 8'h01; step_i = 1'b1;
    tick();
    flag_clr_i = '0; step_i = 1'b0;
    chk("R11 fire beats clear", 32'(evt_flag_o), 1);
    flag_clr_i = 8'h01;
    tick();
    flag_clr_i = '0;
    chk("R11 cleared", 32'(evt_flag_o), 0);
    chk("R12 irq drops", 32'(irq_o), 0);
    int_en_i = '0;

    // R10: direct write only while halted
    cfg_clear();
    wr_out(6'h15);
    chk("R10 halted write", 32'(out_o), 32'h15);
    out_wr_i = 1'b1; out_wr_data_i = 6'h2A;
    tick();
    out_wr_i = 1'b0;
    chk("R10 write ignored when running", 32'(out_o), 32'h15);

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule